// File: doc/BRIEF.md
# Column-Interleaved Mandelbrot Escape Solver

This block computes the Mandelbrot escape iteration count for a subset of the pixels of a raster frame. Several copies run side by side. Each copy has a fixed solver index and knows the total number of copies. It walks only the columns whose index, reduced modulo the copy count, equals its own index. Within each such column it covers every row, from top to bottom. Columns are visited in ascending order.

A start pulse captures four values: the complex coordinate of the frame's top-left pixel, a horizontal step and a vertical step. The solver then derives each pixel's complex coordinate incrementally. For each pixel it runs z ← z² + c in signed fixed point with 27 bits, 23 of them fractional. It stops at the first iterate whose squared magnitude exceeds 4, or when the iteration limit is reached.

Each result is a linear pixel address paired with an iteration count. Results leave on a valid/ready channel toward a shared memory arbiter. A done flag marks the end of the solver's share of the frame.

Top module: `mandel_col_solver`

## Requirements
- R1: Coordinates and iterates are signed two's-complement values 27 bits wide with 23 fractional bits. An iteration computes full-width products and shifts them right arithmetically by 23. The new real part is ((zr·zr − zi·zi) >>> 23) + cr. The new imaginary part is ((2·zr·zi) >>> 23) + ci. Both results are truncated to 27 bits, and z starts at 0.
- R2: The reported count is the index n of the first iterate z_n whose unshifted squared magnitude zr·zr + zi·zi is strictly greater than 4·2^46. A magnitude of exactly 4 does not count as escape.
- R3: A pixel that has not escaped after MAX_ITER iterations (default 1000) reports MAX_ITER. The count output is wide enough to hold MAX_ITER.
- R4: The solver emits results only for columns x with x mod NSOLV = ID. It emits one result for each of the ROWS rows of every such column, and nothing else.
- R5: The result address is y·COLS + x. Results come column by column in ascending x, and top row first within a column.
- R6: The pixel at column x and row y uses cr = left + x·dx and ci = top − y·dy, computed modulo 2^27.
- R7: While out_valid is high and out_ready is low, out_valid, out_addr and out_iter hold their values.
- R8: After a result is accepted, out_valid is low in the next cycle. No new result is computed until the pending one is accepted.
- R9: A start pulse captures the corner and step inputs and restarts the scan from the first owned pixel at any time. Out_valid and done are low in the cycle after start.
- R10: Done rises after the last owned pixel is accepted and stays high, with out_valid low, until the next start.
- R11: After reset, out_valid and done are low and no result appears until a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture configuration and restart the scan |
| cfg_left | input | 27 | Real coordinate of column 0 (4.23) |
| cfg_top | input | 27 | Imaginary coordinate of row 0 (4.23) |
| cfg_dx | input | 27 | Real step per column (4.23) |
| cfg_dy | input | 27 | Imaginary decrement per row (4.23) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result accepted when high with out_valid |
| out_addr | output | ADDR_W | Linear pixel address y·COLS + x |
| out_iter | output | CNT_W | Escape iteration count |
| done | output | 1 | All owned pixels of the frame accepted |

## Verification
The checker enforces several properties on every cycle. The result holds steady under backpressure, valid falls after each acceptance, and every emitted address falls inside the frame and in an owned column. Counts never exceed the cap, done and valid are never high together, and start clears both. Properties cannot show that the counts are the right numbers, that pixels come in the right order, or that each owned pixel appears exactly once. The bench's frame scenarios cover these by comparing against an independent fixed-point model. The scenarios include a point whose magnitude sits exactly at 4, points that escape on the first iterate, points that run to the cap, a restart in the middle of a frame, and three backpressure patterns.

// File: rtl/mandel_pkg.sv
package mandel_pkg;
   localparam int FX_W_DEF    = 27;
   localparam int FX_FRAC_DEF = 23;
   localparam int ITER_CAP_DEF = 1000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KICK,
      ST_RUN,
      ST_OUT,
      ST_DONE
   } solver_st_e;
endpackage

// File: rtl/mandel_iter_core.sv
module mandel_iter_core #(
   parameter int W        = mandel_pkg::FX_W_DEF,
   parameter int FRAC     = mandel_pkg::FX_FRAC_DEF,
   parameter int MAX_ITER = mandel_pkg::ITER_CAP_DEF,
   parameter int CNT_W    = $clog2(MAX_ITER + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                init,
   input  logic signed [W-1:0] cr,
   input  logic signed [W-1:0] ci,
   output logic                finish,
   output logic [CNT_W-1:0]    iters
);
   localparam int P_W = 2 * W + 2;
   localparam logic signed [P_W-1:0] ESC_LIM = P_W'(4) << (2 * FRAC);

   logic signed [W-1:0]   zr, zi, zr_nx, zi_nx;
   logic signed [P_W-1:0] ezr, ezi, sq_r, sq_i, x_ri, mag;
   logic [CNT_W-1:0]      n_q;
   logic                  run_q, fin_q, escaped, at_cap;

   assign ezr  = P_W'(zr);
   assign ezi  = P_W'(zi);
   assign sq_r = ezr * ezr;
   assign sq_i = ezi * ezi;
   assign x_ri = ezr * ezi;
   assign mag  = sq_r + sq_i;

   assign escaped = mag > ESC_LIM;
   assign at_cap  = n_q == CNT_W'(MAX_ITER);

   assign zr_nx = W'((sq_r - sq_i) >>> FRAC) + cr;
   assign zi_nx = W'((x_ri <<< 1) >>> FRAC) + ci;

   always_ff @(posedge clk) begin
      if (rst) begin
         zr    <= '0;
         zi    <= '0;
         n_q   <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (init) begin
            zr    <= '0;
            zi    <= '0;
            n_q   <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (escaped || at_cap) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end else begin
               zr  <= zr_nx;
               zi  <= zi_nx;
               n_q <= n_q + 1'b1;
            end
         end
      end
   end

   assign finish = fin_q;
   assign iters  = n_q;
endmodule

// File: rtl/mandel_col_scan.sv
module mandel_col_scan #(
   parameter int W      = mandel_pkg::FX_W_DEF,
   parameter int COLS   = 640,
   parameter int ROWS   = 480,
   parameter int NSOLV  = 16,
   parameter int ID     = 0,
   parameter int ADDR_W = $clog2(COLS * ROWS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic                advance,
   input  logic signed [W-1:0] left,
   input  logic signed [W-1:0] top,
   input  logic signed [W-1:0] dx,
   input  logic signed [W-1:0] dy,
   output logic signed [W-1:0] cr,
   output logic signed [W-1:0] ci,
   output logic [ADDR_W-1:0]   addr,
   output logic                last
);
   localparam int  X_W  = $clog2(COLS + NSOLV);
   localparam int  Y_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam bit  POW2 = (NSOLV & (NSOLV - 1)) == 0;

   logic signed [W-1:0] dx_q, dy_q, top_q, cr_q, ci_q;
   logic signed [W-1:0] col_step, id_off;
   logic [X_W-1:0]      x_q;
   logic [Y_W-1:0]      y_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                bottom;

   generate
      if (POW2) begin : g_step_shift
         assign col_step = dx_q <<< $clog2(NSOLV);
      end else begin : g_step_mul
         assign col_step = W'(dx_q * W'(NSOLV));
      end
      if (ID == 0) begin : g_off_zero
         assign id_off = '0;
      end else begin : g_off_mul
         assign id_off = W'(dx * W'(ID));
      end
   endgenerate

   assign bottom = y_q == Y_W'(ROWS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         dx_q   <= '0;
         dy_q   <= '0;
         top_q  <= '0;
         cr_q   <= '0;
         ci_q   <= '0;
         x_q    <= X_W'(ID);
         y_q    <= '0;
         addr_q <= ADDR_W'(ID);
      end else if (load) begin
         dx_q   <= dx;
         dy_q   <= dy;
         top_q  <= top;
         cr_q   <= left + id_off;
         ci_q   <= top;
         x_q    <= X_W'(ID);
         y_q    <= '0;
         addr_q <= ADDR_W'(ID);
      end else if (advance) begin
         if (bottom) begin
            y_q    <= '0;
            x_q    <= x_q + X_W'(NSOLV);
            cr_q   <= cr_q + col_step;
            ci_q   <= top_q;
            addr_q <= ADDR_W'(int'(x_q) + NSOLV);
         end else begin
            y_q    <= y_q + 1'b1;
            ci_q   <= ci_q - dy_q;
            addr_q <= addr_q + ADDR_W'(COLS);
         end
      end
   end

   assign cr   = cr_q;
   assign ci   = ci_q;
   assign addr = addr_q;
   assign last = bottom && (int'(x_q) + NSOLV >= COLS);
endmodule

// File: rtl/mandel_col_solver.sv
module mandel_col_solver #(
   parameter int W        = mandel_pkg::FX_W_DEF,
   parameter int FRAC     = mandel_pkg::FX_FRAC_DEF,
   parameter int MAX_ITER = mandel_pkg::ITER_CAP_DEF,
   parameter int COLS     = 640,
   parameter int ROWS     = 480,
   parameter int NSOLV    = 16,
   parameter int ID       = 0,
   localparam int CNT_W   = $clog2(MAX_ITER + 1),
   localparam int ADDR_W  = $clog2(COLS * ROWS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic signed [W-1:0] cfg_left,
   input  logic signed [W-1:0] cfg_top,
   input  logic signed [W-1:0] cfg_dx,
   input  logic signed [W-1:0] cfg_dy,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [ADDR_W-1:0]   out_addr,
   output logic [CNT_W-1:0]    out_iter,
   output logic                done
);
   import mandel_pkg::*;

   generate
      if (ID < 0 || ID >= NSOLV || NSOLV > COLS || NSOLV < 1) begin : g_bad_share
         $error("solver index must be below the solver count, which must not exceed the column count");
      end
      if (FRAC >= W || FRAC < 2) begin : g_bad_fmt
         $error("fraction width must leave integer bits");
      end
      if (MAX_ITER < 1 || ROWS < 1) begin : g_bad_cap
         $error("iteration cap and row count must be positive");
      end
   endgenerate

   solver_st_e          st_q;
   logic signed [W-1:0] cr, ci;
   logic [ADDR_W-1:0]   scan_addr;
   logic                scan_last, scan_adv, core_init, core_fin;
   logic [CNT_W-1:0]    core_iters;

   assign core_init = st_q == ST_KICK;
   assign scan_adv  = st_q == ST_OUT && out_ready && !scan_last && !start;

   mandel_col_scan #(
      .W(W), .COLS(COLS), .ROWS(ROWS), .NSOLV(NSOLV), .ID(ID), .ADDR_W(ADDR_W)
   ) u_scan (
      .clk(clk), .rst(rst), .load(start), .advance(scan_adv),
      .left(cfg_left), .top(cfg_top), .dx(cfg_dx), .dy(cfg_dy),
      .cr(cr), .ci(ci), .addr(scan_addr), .last(scan_last)
   );

   mandel_iter_core #(
      .W(W), .FRAC(FRAC), .MAX_ITER(MAX_ITER), .CNT_W(CNT_W)
   ) u_core (
      .clk(clk), .rst(rst), .init(core_init), .cr(cr), .ci(ci),
      .finish(core_fin), .iters(core_iters)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= ST_IDLE;
      end else if (start) begin
         st_q <= ST_KICK;
      end else begin
         case (st_q)
            ST_KICK: st_q <= ST_RUN;
            ST_RUN:  if (core_fin) st_q <= ST_OUT;
            ST_OUT:  if (out_ready) st_q <= scan_last ? ST_DONE : ST_KICK;
            default: st_q <= st_q;
         endcase
      end
   end

   assign out_valid = st_q == ST_OUT;
   assign out_addr  = scan_addr;
   assign out_iter  = core_iters;
   assign done      = st_q == ST_DONE;
endmodule

// File: rtl/mandel_col_solver_chk.sv
module mandel_col_solver_chk #(
   parameter int MAX_ITER = 1000,
   parameter int COLS     = 640,
   parameter int ROWS     = 480,
   parameter int NSOLV    = 16,
   parameter int ID       = 0,
   localparam int CNT_W   = $clog2(MAX_ITER + 1),
   localparam int ADDR_W  = $clog2(COLS * ROWS)
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic [CNT_W-1:0]  out_iter,
   input logic              done
);
   // R7: pending result frozen under backpressure
   a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready && !start |=> out_valid && $stable(out_addr) && $stable(out_iter));

   // R8: one pixel in flight, so an acceptance leaves a gap
   a_r8_gap_after_accept: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready |=> !out_valid);

   // R3: never above the cap
   a_r3_count_capped: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> int'(out_iter) <= MAX_ITER);

   // R4: only owned columns
   a_r4_owned_column: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_addr) % COLS) % NSOLV == ID);

   // R5: inside the frame
   a_r5_addr_in_frame: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> int'(out_addr) < COLS * ROWS);

   // R10: done and valid exclusive
   a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
      done |-> !out_valid);

   // R9: start clears both flags
   a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
      start |=> !done && !out_valid);
endmodule

bind mandel_col_solver mandel_col_solver_chk #(
   .MAX_ITER(MAX_ITER), .COLS(COLS), .ROWS(ROWS), .NSOLV(NSOLV), .ID(ID)
) u_chk (
   .clk(clk), .rst(rst), .start(start), .out_valid(out_valid),
   .out_ready(out_ready), .out_addr(out_addr), .out_iter(out_iter), .done(done)
);

// File: tb/sim_mandel_col_solver.sv
module sim_mandel_col_solver;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 27;
   localparam int FRAC  = 23;
   localparam int MAXI  = 1000;
   localparam int COLS  = 8;
   localparam int ROWS  = 4;
   localparam int NSOLV = 3;
   localparam int ID    = 1;
   localparam int NCOL_OWN = (COLS - ID + NSOLV - 1) / NSOLV;
   localparam int NPIX  = NCOL_OWN * ROWS;
   localparam int ADDR_W = $clog2(COLS * ROWS);
   localparam int CNT_W  = $clog2(MAXI + 1);
   localparam int FRAME_LIMIT = 30000;
   localparam int WATCHDOG = 190000;

   typedef struct packed {
      logic signed [W-1:0] left;
      logic signed [W-1:0] top;
      logic signed [W-1:0] dx;
      logic signed [W-1:0] dy;
      logic [1:0]          mode;
   } scen_t;

   // corner, steps (4.23) and ready pattern: 0 always, 1 alternate, 2 one in four
   localparam scen_t SCEN [4] = '{
      '{-27'sd16777216, 27'sd8388608,  27'sd3145728, 27'sd4194304, 2'd0},
      '{-27'sd6710886,  27'sd1677722,  27'sd83886,   27'sd83886,   2'd1},
      '{ 27'sd4194304,  27'sd12582912, 27'sd2097152, 27'sd2097152, 2'd2},
      '{-27'sd25165824, 27'sd16777216, 27'sd8388608, 27'sd8388608, 2'd0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic signed [W-1:0] cfg_left = '0, cfg_top = '0, cfg_dx = '0, cfg_dy = '0;
   logic out_ready = 1'b0;
   logic out_valid, done;
   logic [ADDR_W-1:0] out_addr;
   logic [CNT_W-1:0]  out_iter;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mandel_col_solver #(
      .W(W), .FRAC(FRAC), .MAX_ITER(MAXI), .COLS(COLS), .ROWS(ROWS),
      .NSOLV(NSOLV), .ID(ID)
   ) u0 (
      .clk(clk), .rst(rst), .start(start), .cfg_left(cfg_left), .cfg_top(cfg_top),
      .cfg_dx(cfg_dx), .cfg_dy(cfg_dy), .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_iter(out_iter), .done(done)
   );

   task automatic check_eq(string req, string what, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // escape count from the stated fixed-point recurrence
   function automatic int model_iter(logic signed [W-1:0] cr, logic signed [W-1:0] ci);
      logic signed [W-1:0]    zr = '0, zi = '0;
      logic signed [2*W+1:0]  a, b, p, lim;
      lim = 56'sd1 <<< (2 * FRAC + 2);
      for (int n = 0; n <= MAXI; n++) begin
         a = 56'(zr) * 56'(zr);
         b = 56'(zi) * 56'(zi);
         p = 56'(zr) * 56'(zi);
         if (a + b > lim) return n;
         if (n == MAXI) return MAXI;
         zr = W'((a - b) >>> FRAC) + cr;
         zi = W'((p <<< 1) >>> FRAC) + ci;
      end
      return MAXI;
   endfunction

   task automatic pulse_start(int s);
      @(negedge clk);
      cfg_left = SCEN[s].left;
      cfg_top  = SCEN[s].top;
      cfg_dx   = SCEN[s].dx;
      cfg_dy   = SCEN[s].dy;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_eq("R9", "valid after start", out_valid, 0);
      check_eq("R10", "done after start", done, 0);
   endtask

   task automatic run_frame(int s);
      int got = 0;
      int cyc = 0;
      bit holding = 0;
      logic [ADDR_W-1:0] h_addr = '0;
      logic [CNT_W-1:0]  h_iter = '0;
      pulse_start(s);
      while (got < NPIX && cyc < FRAME_LIMIT) begin
         @(negedge clk);
         cyc++;
         if (holding) begin
            check_eq("R7", "valid held", out_valid, 1);
            check_eq("R7", "addr held", out_addr, h_addr);
            check_eq("R7", "iter held", out_iter, h_iter);
            holding = 0;
         end
         case (SCEN[s].mode)
            2'd0:    out_ready = 1'b1;
            2'd1:    out_ready = cyc[0];
            default: out_ready = (cyc % 4) == 0;
         endcase
         if (out_valid) begin
            if (out_ready) begin
               int col = got / ROWS;
               int row = got % ROWS;
               int x   = ID + col * NSOLV;
               logic signed [W-1:0] cr = W'(SCEN[s].left + W'(x) * SCEN[s].dx);
               logic signed [W-1:0] ci = W'(SCEN[s].top - W'(row) * SCEN[s].dy);
               int exp_it = model_iter(cr, ci);
               check_eq("R4 R5", "pixel address", out_addr, row * COLS + x);
               check_eq(exp_it == MAXI ? "R3 R6" : "R1 R2 R6", "iteration count",
                        out_iter, exp_it);
               got++;
            end else begin
               holding = 1;
               h_addr  = out_addr;
               h_iter  = out_iter;
            end
         end
      end
      check_eq("R4", "owned pixels delivered", got, NPIX);
      @(negedge clk);
      check_eq("R8", "valid after final accept", out_valid, 0);
      @(negedge clk);
      check_eq("R10", "done after final accept", done, 1);
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R10", "done stays high", done, 1);
      check_eq("R10", "no result while done", out_valid, 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_eq("R11", "valid in reset", out_valid, 0);
      check_eq("R11", "done in reset", done, 0);
      rst = 1'b0;
      out_ready = 1'b1;
      repeat (20) @(negedge clk);
      check_eq("R11", "valid idle without start", out_valid, 0);
      check_eq("R11", "done idle without start", done, 0);

      // table of views walked in order
      for (int s = 0; s < 4; s++) run_frame(s);

      // R2 boundary: c = -2 sits at magnitude exactly 4 and must run to the cap
      check_eq("R2", "model at magnitude 4", model_iter(-27'sd16777216, 27'sd0), MAXI);
      // first-iterate escape: c = 4
      check_eq("R2", "model first escape", model_iter(27'sd33554432, 27'sd0), 1);

      // R9: restart mid-frame with a result stalled
      pulse_start(0);
      out_ready = 1'b0;
      repeat (1500) @(negedge clk);
      check_eq("R8", "stalled result pending", out_valid, 1);
      run_frame(2);

      // R9: restart again while the core is busy on a capped pixel
      pulse_start(3);
      out_ready = 1'b1;
      repeat (40) @(negedge clk);
      run_frame(1);

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule